// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This block sits between a byte-wide register bus and a multi-input 10-bit converter. It runs one conversion at a time, and that conversion averages 1, 4, 8 or 16 converter samples. There are two ways to start a conversion. Software can start one by writing a start bit. In hardware-trigger mode, a chosen edge of an external trigger pin starts one after a programmable delay, counted in ticks of a slow timebase. Each kind of conversion has its own setup register, its own result register pair and its own one-cycle completion interrupt. Channel codes 0x1C to 0x1F are dual channels: the converter also returns a second (current) sample for each sample, and the block averages that stream into a separate result pair.

For every sample, the block raises `adc_start` for one cycle and keeps `adc_sel` and `adc_avg` steady. The converter answers with `smp_valid` together with both sample codes. The returned sample stream has no back-pressure. A sample is taken only while a request is outstanding, and a sample that arrives at any other time is dropped. The front-end switch bits of the control register are only stored and brought out on `fe_ctl`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and `busy`, `adc_start`, `irq_sw` and `irq_hw` are low.
- R2: Register map by address:
  - 0x0 is control. Bit 0 is enable, bit 1 is trigger enable, bit 2 is start, bit 4 selects the edge (0 rising, 1 falling), and bits 3, 5, 6, 7 are front-end switches.
  - 0x1 is software setup and 0x2 is hardware setup. In each, the channel is in bits 4:0 and the averaging code is in bits 6:5.
  - 0x3 is the trigger delay.
  - 0x4 is status, with busy in bit 0.
  - 0x5/0x6 is the software result (low byte, then bits 9:8 in bits 1:0).
  - 0x7/0x8 is the hardware result.
  - 0x9/0xA is the second result.
  - Setup and delay registers read back as written. Writes to 0x4 to 0xA have no effect.
- R3: A control write with bit 0 and bit 2 set while idle starts a software conversion on the channel in register 0x1. `busy` stays high until the conversion completes. A start written with bit 0 clear starts nothing.
- R4: Averaging codes 0, 1, 2 and 3 select 1, 4, 8 and 16 samples. Exactly that many `adc_start` pulses are issued, and the result is the floor of the sample sum divided by the count.
- R5: A software conversion writes its result to 0x5/0x6 and pulses `irq_sw` for exactly one cycle. The result is readable from the cycle after the pulse, and `busy` is low by then.
- R6: A conversion on channel 0x1C to 0x1F also stores the average of `smp_code2` in 0x9/0xA. Conversions on other channels leave 0x9/0xA unchanged.
- R7: With bits 0 and 1 set, a trigger edge waits for the number of `tick_32k` pulses held in register 0x3 (0 to 255), with `busy` high during the wait. It then converts with the setup in register 0x2, writes 0x7/0x8 and pulses `irq_hw` for one cycle.
- R8: In hardware-trigger mode, an edge of the polarity not selected by bit 4 starts nothing.
- R9: A trigger edge is ignored while register 0x2 holds a dual channel (0x1C to 0x1F).
- R10: A start request or trigger edge that arrives while busy is ignored. The start bit always reads back as 0.
- R11: A control write with bit 0 clear ends any conversion or pending delay: `busy` is low in the next cycle, no interrupt follows, and all results are kept.
- R12: A result pair changes only when a conversion of its own kind completes. Software conversions leave 0x7/0x8 alone, and hardware conversions leave 0x5/0x6 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| trig_in | input | 1 | External conversion trigger (already synchronous) |
| tick_32k | input | 1 | One-cycle pulse per slow timebase period |
| fe_ctl | output | 4 | Stored front-end switch bits {7,6,5,3} of control |
| adc_sel | output | 5 | Channel select for the current conversion |
| adc_avg | output | 2 | Averaging code for the current conversion |
| adc_start | output | 1 | One-cycle request for one converter sample |
| busy | output | 1 | Conversion or trigger delay in progress |
| smp_valid | input | 1 | Converter sample valid |
| smp_code | input | DATA_W | Main sample code |
| smp_code2 | input | DATA_W | Second (current) sample code |
| irq_sw | output | 1 | Software conversion complete pulse |
| irq_hw | output | 1 | Hardware conversion complete pulse |

## Verification
The bench builds the block with its default parameters: 10-bit samples, a 14-bit accumulator (up to 16 samples) and an 8-bit delay. At these sizes every software channel code can be crossed with every averaging code, which covers all four dual channels and all four sample counts. Hardware conversions are swept over delays 0 to 3 with both edge polarities. The stub converter gives every sample a value derived from its channel and a running sample index, so the bench can compute each expected average by plain arithmetic.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CH_W = 5;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_SWCFG = 4'h1;
  localparam logic [3:0] A_HWCFG = 4'h2;
  localparam logic [3:0] A_DLY   = 4'h3;
  localparam logic [3:0] A_STAT  = 4'h4;
  localparam logic [3:0] A_SWLO  = 4'h5;
  localparam logic [3:0] A_SWHI  = 4'h6;
  localparam logic [3:0] A_HWLO  = 4'h7;
  localparam logic [3:0] A_HWHI  = 4'h8;
  localparam logic [3:0] A_X2LO  = 4'h9;
  localparam logic [3:0] A_X2HI  = 4'hA;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  // log2 of the sample count for an averaging code
  function automatic logic [2:0] avg_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // channels that return a second result stream
  function automatic logic is_dual(input logic [CH_W-1:0] ch);
    return ch[CH_W-1:CH_W-3] == 3'b111;
  endfunction

endpackage

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              we_sw,
  input  logic              we_hw,
  input  logic              we_x2,
  input  logic [DATA_W-1:0] res_main,
  input  logic [DATA_W-1:0] res_aux,
  output logic              en,
  output logic              trig_en,
  output logic              trig_fall,
  output logic [3:0]        fe_ctl,
  output logic [CH_W-1:0]   sw_ch,
  output logic [1:0]        sw_avg,
  output logic [CH_W-1:0]   hw_ch,
  output logic [1:0]        hw_avg,
  output logic [DLY_W-1:0]  dly,
  output logic [7:0]        rdata
);

  logic [7:0]        ctrl_q, swcfg_q, hwcfg_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DATA_W-1:0] sw_res, hw_res, x2_res;
  logic [15:0]       sw_pad, hw_pad, x2_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      swcfg_q <= '0;
      hwcfg_q <= '0;
      dly_q   <= '0;
      sw_res  <= '0;
      hw_res  <= '0;
      x2_res  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CTRL:  ctrl_q  <= wdata & 8'hFB;   // start bit is never stored
          A_SWCFG: swcfg_q <= wdata;
          A_HWCFG: hwcfg_q <= wdata;
          A_DLY:   dly_q   <= wdata[DLY_W-1:0];
          default: ;
        endcase
      end
      if (we_sw) sw_res <= res_main;
      if (we_hw) hw_res <= res_main;
      if (we_x2) x2_res <= res_aux;
    end
  end

  assign en        = ctrl_q[0];
  assign trig_en   = ctrl_q[1];
  assign trig_fall = ctrl_q[4];
  assign fe_ctl    = {ctrl_q[7], ctrl_q[6], ctrl_q[5], ctrl_q[3]};
  assign sw_ch     = swcfg_q[CH_W-1:0];
  assign sw_avg    = swcfg_q[6:5];
  assign hw_ch     = hwcfg_q[CH_W-1:0];
  assign hw_avg    = hwcfg_q[6:5];
  assign dly       = dly_q;

  assign sw_pad = 16'(sw_res);
  assign hw_pad = 16'(hw_res);
  assign x2_pad = 16'(x2_res);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_SWCFG: rdata = swcfg_q;
      A_HWCFG: rdata = hwcfg_q;
      A_DLY:   rdata = 8'(dly_q);
      A_STAT:  rdata = {7'b0, busy};
      A_SWLO:  rdata = sw_pad[7:0];
      A_SWHI:  rdata = sw_pad[15:8];
      A_HWLO:  rdata = hw_pad[7:0];
      A_HWHI:  rdata = hw_pad[15:8];
      A_X2LO:  rdata = x2_pad[7:0];
      A_X2HI:  rdata = x2_pad[15:8];
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_trig.sv
module adc_trig #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             fall_sel,
  input  logic             arm,
  input  logic             abort,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             fire,
  output logic             waiting
);

  logic             prev;
  logic [DLY_W-1:0] cnt;
  logic             edge_seen;

  assign edge_seen = fall_sel ? (prev & ~trig_in) : (~prev & trig_in);
  assign fire      = waiting && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      cnt     <= '0;
      waiting <= 1'b0;
    end else begin
      prev <= trig_in;
      if (abort) begin
        waiting <= 1'b0;
      end else if (!waiting) begin
        if (arm && edge_seen) begin
          waiting <= 1'b1;
          cnt     <= dly;
        end
      end else if (cnt == '0) begin
        waiting <= 1'b0;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_acc.sv
module adc_acc #(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  input  logic [2:0]        shift,
  output logic [DATA_W-1:0] avg
);

  logic [ACC_W-1:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum + ACC_W'(din);
  end

  assign avg = DATA_W'(sum >> shift);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 14,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              trig_in,
  input  logic              tick_32k,
  output logic [3:0]        fe_ctl,
  output logic [CH_W-1:0]   adc_sel,
  output logic [1:0]        adc_avg,
  output logic              adc_start,
  output logic              busy,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_code,
  input  logic [DATA_W-1:0] smp_code2,
  output logic              irq_sw,
  output logic              irq_hw
);

  localparam int CNT_W = ACC_W - DATA_W;   // log2 of the largest sample count
  localparam int LANES = 2;

  seq_state_e        st;
  logic [CH_W-1:0]   cur_ch;
  logic [1:0]        cur_avg;
  logic              cur_hw;
  logic [CNT_W-1:0]  n_cnt;

  logic              en, trig_en, trig_fall;
  logic [CH_W-1:0]   sw_ch, hw_ch;
  logic [1:0]        sw_avg, hw_avg;
  logic [DLY_W-1:0]  dly;
  logic              fire, waiting;
  logic              ctrl_wr, abort, sw_go, hw_go, go, arm, last;
  logic [2:0]        shift;
  logic              we_sw, we_hw, we_x2;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_avg [LANES];

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign abort   = ctrl_wr && !reg_wdata[0];
  assign busy    = (st != ST_IDLE) || waiting;
  assign sw_go   = ctrl_wr && reg_wdata[0] && reg_wdata[2] && !busy;
  assign arm     = en && trig_en && (st == ST_IDLE) && !is_dual(hw_ch);
  assign hw_go   = fire && trig_en;
  assign go      = sw_go || hw_go;
  assign shift   = avg_shift(cur_avg);
  assign last    = n_cnt == CNT_W'((1 << shift) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_ch  <= '0;
      cur_avg <= '0;
      cur_hw  <= 1'b0;
      n_cnt   <= '0;
    end else if (abort) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st      <= ST_REQ;
          cur_ch  <= hw_go ? hw_ch  : sw_ch;
          cur_avg <= hw_go ? hw_avg : sw_avg;
          cur_hw  <= hw_go;
          n_cnt   <= '0;
        end
        ST_REQ:  st <= ST_WAIT;
        ST_WAIT: if (smp_valid) begin
          if (last) begin
            st <= ST_FIN;
          end else begin
            n_cnt <= n_cnt + 1'b1;
            st    <= ST_REQ;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign adc_start = (st == ST_REQ);
  assign adc_sel   = cur_ch;
  assign adc_avg   = cur_avg;
  assign we_sw     = (st == ST_FIN) && !cur_hw;
  assign we_hw     = (st == ST_FIN) && cur_hw;
  assign we_x2     = we_sw && is_dual(cur_ch);
  assign irq_sw    = we_sw;
  assign irq_hw    = we_hw;

  assign lane_in[0] = smp_code;
  assign lane_in[1] = smp_code2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go && (st == ST_IDLE)),
      .add   ((st == ST_WAIT) && smp_valid),
      .din   (lane_in[g]),
      .shift (shift),
      .avg   (lane_avg[g])
    );
  end

  adc_trig #(.DLY_W(DLY_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .fall_sel (trig_fall),
    .arm      (arm),
    .abort    (abort),
    .tick     (tick_32k),
    .dly      (dly),
    .fire     (fire),
    .waiting  (waiting)
  );

  adc_regfile #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy),
    .we_sw     (we_sw),
    .we_hw     (we_hw),
    .we_x2     (we_x2),
    .res_main  (lane_avg[0]),
    .res_aux   (lane_avg[1]),
    .en        (en),
    .trig_en   (trig_en),
    .trig_fall (trig_fall),
    .fe_ctl    (fe_ctl),
    .sw_ch     (sw_ch),
    .sw_avg    (sw_avg),
    .hw_ch     (hw_ch),
    .hw_avg    (hw_avg),
    .dly       (dly),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       adc_start,
  input logic       busy,
  input logic       irq_sw,
  input logic       irq_hw
);

  // R5
  irq_sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sw |=> !irq_sw);

  // R7
  irq_hw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hw |=> !irq_hw);

  // R12
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_sw, irq_hw}));

  // R3
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);

  // R4
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R5
  idle_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sw || irq_hw) |=> !busy);

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h0 && !reg_wdata[0]) |=> (!busy && !irq_sw && !irq_hw));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .adc_start (adc_start),
  .busy      (busy),
  .irq_sw    (irq_sw),
  .irq_hw    (irq_hw)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       trig_in = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] fe_ctl;
  logic [4:0] adc_sel;
  logic [1:0] adc_avg;
  logic       adc_start, busy, irq_sw, irq_hw;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic [9:0] smp_code2 = '0;

  int checks = 0;
  int errors = 0;
  int scnt = 0;
  int starts = 0;
  int cd = 0;
  int exp_sw = 0, exp_hw = 0, exp_x2 = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .tick_32k(tick_32k), .fe_ctl(fe_ctl), .adc_sel(adc_sel), .adc_avg(adc_avg),
    .adc_start(adc_start), .busy(busy), .smp_valid(smp_valid),
    .smp_code(smp_code), .smp_code2(smp_code2), .irq_sw(irq_sw), .irq_hw(irq_hw)
  );

  function automatic int fm(input int ch, input int k);
    return (ch * 97 + k * 331 + 5) % 1024;
  endfunction

  function automatic int fa(input int ch, input int k);
    return (ch * 53 + k * 613 + 900) % 1024;
  endfunction

  // behavioural converter: answers each request three cycles later
  always @(posedge clk) begin
    smp_valid <= 1'b0;
    if (adc_start) begin
      starts <= starts + 1;
      cd <= 3;
    end else if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        smp_valid <= 1'b1;
        smp_code  <= 10'(fm(int'(adc_sel), scnt));
        smp_code2 <= 10'(fa(int'(adc_sel), scnt));
        scnt      <= scnt + 1;
      end
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    v = int'({hi, lo});
  endtask

  task automatic wait_irq(input bit hw);
    int t = 0;
    while (t < 3000) begin
      @(negedge clk);
      if (hw ? irq_hw : irq_sw) break;
      t++;
    end
    chk_eq(hw ? "R7 irq_hw seen" : "R5 irq_sw seen", int'(t < 3000), 1);
    @(negedge clk);
    chk_eq(hw ? "R7 irq_hw one cycle" : "R5 irq_sw one cycle", int'(hw ? irq_hw : irq_sw), 0);
    chk_eq("R5 busy low after completion", int'(busy), 0);
  endtask

  function automatic int navg(input int av);
    return (av == 0) ? 1 : (av == 1) ? 4 : (av == 2) ? 8 : 16;
  endfunction

  task automatic sw_conv(input int ch, input int av);
    int n, s0, st0, em, ex, v;
    n = navg(av);
    wr(4'h1, 8'((av << 5) | ch));
    s0 = scnt; st0 = starts;
    wr(4'h0, 8'h45);
    wait_irq(1'b0);
    em = 0; ex = 0;
    for (int i = 0; i < n; i++) begin
      em += fm(ch, s0 + i);
      ex += fa(ch, s0 + i);
    end
    em = em / n; ex = ex / n;
    exp_sw = em;
    if (ch >= 28) exp_x2 = ex;
    rd16(4'h5, v); chk_eq("R4 R5 software average result", v, em);
    chk_eq("R4 sample request count", starts - st0, n);
    rd16(4'h9, v); chk_eq("R6 second result", v, exp_x2);
    rd16(4'h7, v); chk_eq("R12 hardware result kept", v, exp_hw);
  endtask

  task automatic hw_conv(input int ch, input int av, input int d, input bit fall);
    int n, s0, st0, em, v;
    n = navg(av);
    wr(4'h0, 8'h01);
    trig_in = fall;
    wr(4'h2, 8'((av << 5) | ch));
    wr(4'h3, 8'(d));
    wr(4'h0, fall ? 8'h53 : 8'h43);
    s0 = scnt; st0 = starts;
    @(negedge clk);
    trig_in = ~fall;
    for (int i = 0; i < d; i++) begin
      repeat (2) @(negedge clk);
      if (i == d - 1) begin
        chk_eq("R7 no start before delay ends", starts - st0, 0);
        chk_eq("R7 busy during delay", int'(busy), 1);
      end
      tick_32k = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0;
    end
    wait_irq(1'b1);
    em = 0;
    for (int i = 0; i < n; i++) em += fm(ch, s0 + i);
    em = em / n;
    exp_hw = em;
    rd16(4'h7, v); chk_eq("R7 hardware result", v, em);
    chk_eq("R4 R7 hardware sample count", starts - st0, n);
    rd16(4'h5, v); chk_eq("R12 software result kept", v, exp_sw);
    wr(4'h0, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int s0, st0, v, irqs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), d);
      chk_eq("R1 register reset value", int'(d), 0);
    end
    chk_eq("R1 outputs idle", int'({busy, adc_start, irq_sw, irq_hw}), 0);

    // R2 register map and read-only addresses
    wr(4'h1, 8'hA5); rd(4'h1, d); chk_eq("R2 sw setup readback", int'(d), 8'hA5);
    wr(4'h2, 8'h5A); rd(4'h2, d); chk_eq("R2 hw setup readback", int'(d), 8'h5A);
    wr(4'h3, 8'hC3); rd(4'h3, d); chk_eq("R2 delay readback", int'(d), 8'hC3);
    for (int a = 4; a <= 10; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), d);
      chk_eq("R2 read-only register unchanged", int'(d), 0);
    end
    st0 = starts;
    wr(4'h0, 8'hBE);
    rd(4'h0, d); chk_eq("R2 R10 control readback, start reads 0", int'(d), 8'hBA);
    chk_eq("R2 fe_ctl bits", int'(fe_ctl), 4'b1011);
    repeat (10) @(negedge clk);
    chk_eq("R3 start without enable ignored", starts - st0 + int'(busy), 0);
    wr(4'h0, 8'h00);

    // R3 R4 R5 R6: every channel crossed with every averaging code
    for (int ch = 0; ch < 32; ch++)
      for (int av = 0; av < 4; av++)
        sw_conv(ch, av);

    // R7: hardware conversions, delays 0..3, both edges
    for (int k = 0; k < 4; k++)
      for (int av = 0; av < 4; av++)
        hw_conv((k == 0) ? 2 : (k == 1) ? 8 : (k == 2) ? 19 : 27, av, (k + av) % 4, av[0]);
    sw_conv(30, 1);

    // R8: opposite edge ignored in falling mode
    wr(4'h0, 8'h01); trig_in = 1'b0;
    wr(4'h2, 8'h04); wr(4'h3, 8'h00);
    wr(4'h0, 8'h53);
    s0 = scnt; st0 = starts;
    @(negedge clk); trig_in = 1'b1;
    repeat (20) @(negedge clk);
    chk_eq("R8 rising edge ignored in falling mode", starts - st0 + int'(busy), 0);
    trig_in = 1'b0;
    wait_irq(1'b1);
    exp_hw = fm(4, s0);
    rd16(4'h7, v); chk_eq("R8 falling edge converts", v, exp_hw);
    wr(4'h0, 8'h01);

    // R9: dual channel rejected for hardware trigger
    trig_in = 1'b0;
    wr(4'h2, 8'h1E);
    wr(4'h0, 8'h43);
    st0 = starts;
    @(negedge clk); trig_in = 1'b1;
    repeat (30) @(negedge clk);
    chk_eq("R9 dual channel trigger ignored", starts - st0 + int'(busy), 0);
    wr(4'h0, 8'h01); trig_in = 1'b0;

    // R10: start while busy ignored, start bit self-clears
    wr(4'h1, 8'h65);
    s0 = scnt; st0 = starts;
    wr(4'h0, 8'h45);
    rd(4'h0, d); chk_eq("R10 start bit reads 0", int'(d), 8'h41);
    wr(4'h1, 8'h09);
    wr(4'h0, 8'h45);
    wait_irq(1'b0);
    v = 0;
    for (int i = 0; i < 16; i++) v += fm(5, s0 + i);
    exp_sw = v / 16;
    rd16(4'h5, v); chk_eq("R10 first conversion result kept", v, exp_sw);
    chk_eq("R10 no second conversion", starts - st0, 16);

    // R11: abort software conversion and pending delay
    irqs = 0;
    wr(4'h1, 8'h63);
    wr(4'h0, 8'h45);
    repeat (10) @(negedge clk);
    wr(4'h0, 8'h00);
    chk_eq("R11 busy low after abort", int'(busy), 0);
    rd(4'h4, d); chk_eq("R11 status after abort", int'(d), 0);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (irq_sw || irq_hw) irqs++;
    end
    chk_eq("R11 no interrupt after abort", irqs, 0);
    rd16(4'h5, v); chk_eq("R11 software result kept", v, exp_sw);
    trig_in = 1'b0;
    wr(4'h2, 8'h02); wr(4'h3, 8'h05);
    wr(4'h0, 8'h43);
    st0 = starts;
    @(negedge clk); trig_in = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R11 busy during delay", int'(busy), 1);
    wr(4'h0, 8'h00);
    chk_eq("R11 delay aborted", int'(busy), 0);
    for (int i = 0; i < 8; i++) begin
      tick_32k = 1'b1; @(negedge clk); tick_32k = 1'b0; @(negedge clk);
    end
    chk_eq("R11 no start after aborted delay", starts - st0, 0);
    rd16(4'h7, v); chk_eq("R11 hardware result kept", v, exp_hw);

    // R3: a fresh start works after the abort
    sw_conv(12, 2);

    finish_run();
  end

endmodule